// File: doc/BRIEF.md
# Address-Targeted Translation Cache Invalidation Engine

This block is a small, fully associative translation cache. It has three ports: a write port that installs entries, a lookup port that answers translation queries, and a command port that removes cached translations for one virtual page. Each entry records the following:

- a virtual page number
- an 8-bit address-space identifier (ASID)
- a global flag
- a leaf-level flag
- a regime tag
- a virtual-machine identifier (VMID)
- a security-state tag

An invalidate command carries a 32-bit operand that packs the page and the ASID. It also carries the target regime, a VMID, a security state and a flag that enables the VMID compare. Once the command is accepted, the engine walks the array one entry per clock. It clears every leaf entry that matches the command and leaves walk-level entries in place. At the end it pulses a completion strobe.

While the walk runs, the command port is not ready and lookups are stalled, so a translation that is about to be removed is never returned. The regime tag takes two values. Value 0 is the guest regime, whose entries are VMID-tagged. Value 1 is the monitor regime, which has no VMID. The caller picks the regime, VMID and security state that go with the privilege level that issued the command.

Top module: `xlat_inv_engine`

## Requirements
- R1: After reset every entry is invalid: lookups miss, inv_ready is 1 and inv_done is 0.
- R2: A lookup answers one cycle after lk_valid. It hits when a valid entry has an equal regime, security and page, an equal VMID (guest regime only), and either an equal ASID or the global flag set. lk_index reports the lowest matching entry.
- R3: The invalidate operand is split as follows: bits 31:12 are the page, bits 7:0 are the ASID, and bits 11:8 have no effect on which entries are removed.
- R4: A non-global entry is removed only when both its page and its ASID equal the operand fields.
- R5: A global entry is removed when its page matches, whatever its stored ASID and the operand ASID.
- R6: Entries whose leaf flag is 0 are never removed by an invalidate.
- R7: For a guest-regime command (regime 0), only guest entries with an equal security state are removed. When inv_vmid_cmp is 1, the entry's VMID must also equal inv_vmid. When inv_vmid_cmp is 0, any VMID matches.
- R8: For a monitor-regime command (regime 1), only monitor entries with an equal security state are removed, and the VMID is never compared, even when inv_vmid_cmp is 1.
- R9: A command is accepted when inv_valid and inv_ready are both 1. inv_ready then stays 0 for exactly NUM_ENTRIES cycles, and it returns to 1 in the same cycle as a single-cycle inv_done pulse.
- R10: lk_stall is 1 while a walk is in progress, and a lookup presented during the walk returns no hit.
- R11: A write presented while a walk is in progress is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Install an entry |
| wr_idx | input | IDX_W | Slot to write |
| wr_vpn | input | 20 | Page number of the new entry |
| wr_asid | input | 8 | ASID of the new entry |
| wr_global | input | 1 | Global flag of the new entry |
| wr_leaf | input | 1 | Leaf-level flag of the new entry |
| wr_regime | input | 1 | Regime tag (0 guest, 1 monitor) |
| wr_vmid | input | 8 | VMID of the new entry |
| wr_secure | input | 1 | Security-state tag of the new entry |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Page to look up |
| lk_asid | input | 8 | Current ASID |
| lk_regime | input | 1 | Current regime |
| lk_vmid | input | 8 | Current VMID |
| lk_secure | input | 1 | Current security state |
| lk_stall | output | 1 | Lookups are held off by a walk |
| lk_hit | output | 1 | Registered lookup hit |
| lk_index | output | IDX_W | Lowest hitting slot |
| inv_valid | input | 1 | Invalidate command present |
| inv_ready | output | 1 | Engine idle, command can be taken |
| inv_operand | input | 32 | Page in 31:12, ASID in 7:0 |
| inv_regime | input | 1 | Target regime |
| inv_vmid | input | 8 | Target VMID |
| inv_secure | input | 1 | Target security state |
| inv_vmid_cmp | input | 1 | Compare VMID (guest regime only) |
| inv_done | output | 1 | One-cycle completion strobe |

## Verification
The removal logic is driven with several entry sets:

- Entries that differ only in ASID separate the non-global rule from the global one.
- A pair that differs only in the leaf flag shows that walk-level entries survive.
- A block of entries that differ one at a time in VMID, security state and regime shows which filter each command applies, including the VMID-compare-off case and the monitor-regime case.

The operand is sent with its reserved bits set to prove they are ignored. Lookups and writes are issued in the middle of a walk to show the stall and the write drop. Every command is timed cycle by cycle against the ready/done handshake.

// File: rtl/xinv_pkg.sv
package xinv_pkg;
    localparam int VPN_W  = 20;
    localparam int ASID_W = 8;
    localparam int VMID_W = 8;
    localparam int OPND_W = 32;

    typedef enum logic {
        RGM_GUEST   = 1'b0,
        RGM_MONITOR = 1'b1
    } regime_e;

    typedef struct packed {
        logic              vld;
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic              glb;
        logic              leaf;
        regime_e           rgm;
        logic [VMID_W-1:0] vmid;
        logic              sec;
    } xlat_entry_t;
endpackage

// File: rtl/xinv_lkp_match.sv
module xinv_lkp_match
    import xinv_pkg::*;
(
    input  xlat_entry_t       ent,
    input  logic [VPN_W-1:0]  vpn,
    input  logic [ASID_W-1:0] asid,
    input  regime_e           rgm,
    input  logic [VMID_W-1:0] vmid,
    input  logic              sec,
    output logic              hit
);
    logic tag_ok;
    logic addr_ok;

    always_comb begin
        tag_ok  = (ent.rgm == rgm) && (ent.sec == sec) &&
                  ((rgm == RGM_MONITOR) || (ent.vmid == vmid));
        addr_ok = (ent.vpn == vpn) && (ent.glb || (ent.asid == asid));
        hit     = ent.vld && tag_ok && addr_ok;
    end
endmodule

// File: rtl/xinv_kill_match.sv
module xinv_kill_match
    import xinv_pkg::*;
(
    input  xlat_entry_t       ent,
    input  logic [VPN_W-1:0]  vpn,
    input  logic [ASID_W-1:0] asid,
    input  regime_e           rgm,
    input  logic [VMID_W-1:0] vmid,
    input  logic              sec,
    input  logic              vmid_cmp,
    output logic              kill
);
    logic scope_ok;
    logic addr_ok;

    always_comb begin
        scope_ok = (ent.rgm == rgm) && (ent.sec == sec) &&
                   (!vmid_cmp || (ent.vmid == vmid));
        addr_ok  = (ent.vpn == vpn) && (ent.glb || (ent.asid == asid));
        kill     = ent.vld && ent.leaf && scope_ok && addr_ok;
    end
endmodule

// File: rtl/xinv_first_set.sv
module xinv_first_set #(
    parameter int WIDTH = 8,
    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic [WIDTH-1:0] vec,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (vec[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/xlat_inv_engine.sv
module xlat_inv_engine
    import xinv_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [19:0]       wr_vpn,
    input  logic [7:0]        wr_asid,
    input  logic              wr_global,
    input  logic              wr_leaf,
    input  logic              wr_regime,
    input  logic [7:0]        wr_vmid,
    input  logic              wr_secure,
    input  logic              lk_valid,
    input  logic [19:0]       lk_vpn,
    input  logic [7:0]        lk_asid,
    input  logic              lk_regime,
    input  logic [7:0]        lk_vmid,
    input  logic              lk_secure,
    output logic              lk_stall,
    output logic              lk_hit,
    output logic [IDX_W-1:0]  lk_index,
    input  logic              inv_valid,
    output logic              inv_ready,
    input  logic [31:0]       inv_operand,
    input  logic              inv_regime,
    input  logic [7:0]        inv_vmid,
    input  logic              inv_secure,
    input  logic              inv_vmid_cmp,
    output logic              inv_done
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);
    localparam int OP_VPN_LSB = OPND_W - VPN_W;

    typedef struct packed {
        logic              busy;
        logic [IDX_W-1:0]  idx;
        logic              done;
        logic [VPN_W-1:0]  c_vpn;
        logic [ASID_W-1:0] c_asid;
        regime_e           c_rgm;
        logic [VMID_W-1:0] c_vmid;
        logic              c_sec;
        logic              c_vcmp;
        logic              lk_hit;
        logic [IDX_W-1:0]  lk_idx;
    } ctl_t;

    ctl_t        ctl_d, ctl_q;
    xlat_entry_t ent_d [NUM_ENTRIES];
    xlat_entry_t ent_q [NUM_ENTRIES];

    logic [NUM_ENTRIES-1:0] lk_vec;
    logic                   lk_any;
    logic [IDX_W-1:0]       lk_first;
    logic                   sweep_kill;
    xlat_entry_t            sweep_ent;

    // Parallel lookup comparators, one per slot
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_lkp
        xinv_lkp_match u_lkp (
            .ent  (ent_q[g]),
            .vpn  (lk_vpn),
            .asid (lk_asid),
            .rgm  (regime_e'(lk_regime)),
            .vmid (lk_vmid),
            .sec  (lk_secure),
            .hit  (lk_vec[g])
        );
    end

    xinv_first_set #(.WIDTH(NUM_ENTRIES)) u_first (
        .vec (lk_vec),
        .any (lk_any),
        .idx (lk_first)
    );

    // Single comparator shared by the sequential walk
    assign sweep_ent = ent_q[ctl_q.idx];

    xinv_kill_match u_kill (
        .ent      (sweep_ent),
        .vpn      (ctl_q.c_vpn),
        .asid     (ctl_q.c_asid),
        .rgm      (ctl_q.c_rgm),
        .vmid     (ctl_q.c_vmid),
        .sec      (ctl_q.c_sec),
        .vmid_cmp (ctl_q.c_vcmp),
        .kill     (sweep_kill)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ent_d      = ent_q;
        ctl_d.done = 1'b0;

        // Registered lookup response; suppressed during a walk
        ctl_d.lk_hit = lk_valid && !ctl_q.busy && lk_any;
        ctl_d.lk_idx = lk_any ? lk_first : '0;

        if (ctl_q.busy) begin
            if (sweep_kill) begin
                ent_d[ctl_q.idx].vld = 1'b0;
            end
            if (ctl_q.idx == LAST_IDX) begin
                ctl_d.busy = 1'b0;
                ctl_d.done = 1'b1;
                ctl_d.idx  = '0;
            end else begin
                ctl_d.idx = ctl_q.idx + 1'b1;
            end
        end else if (inv_valid) begin
            ctl_d.busy   = 1'b1;
            ctl_d.idx    = '0;
            ctl_d.c_vpn  = inv_operand[OPND_W-1:OP_VPN_LSB];
            ctl_d.c_asid = inv_operand[ASID_W-1:0];
            ctl_d.c_rgm  = regime_e'(inv_regime);
            ctl_d.c_vmid = inv_vmid;
            ctl_d.c_sec  = inv_secure;
            // Monitor regime carries no VMID: compare forced off
            ctl_d.c_vcmp = inv_vmid_cmp && (regime_e'(inv_regime) == RGM_GUEST);
        end

        if (wr_en && !ctl_q.busy) begin
            ent_d[wr_idx].vld  = 1'b1;
            ent_d[wr_idx].vpn  = wr_vpn;
            ent_d[wr_idx].asid = wr_asid;
            ent_d[wr_idx].glb  = wr_global;
            ent_d[wr_idx].leaf = wr_leaf;
            ent_d[wr_idx].rgm  = regime_e'(wr_regime);
            ent_d[wr_idx].vmid = wr_vmid;
            ent_d[wr_idx].sec  = wr_secure;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                ent_q[i] <= '0;
            end
        end else begin
            ctl_q <= ctl_d;
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                ent_q[i] <= ent_d[i];
            end
        end
    end

    assign inv_ready = !ctl_q.busy;
    assign inv_done  = ctl_q.done;
    assign lk_stall  = ctl_q.busy;
    assign lk_hit    = ctl_q.lk_hit;
    assign lk_index  = ctl_q.lk_idx;
endmodule

// File: rtl/xlat_inv_engine_chk.sv
module xlat_inv_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic inv_valid,
    input logic inv_ready,
    input logic inv_done,
    input logic lk_valid,
    input logic lk_stall,
    input logic lk_hit
);
    // R9
    accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && inv_ready) |=> !inv_ready);

    // R9
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_done |=> !inv_done);

    // R9
    done_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_done |-> inv_ready);

    // R9
    ready_return_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(inv_ready) |-> inv_done);

    // R10
    stall_blocks_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_stall |=> !lk_hit);

    // R2
    hit_needs_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> $past(lk_valid));
endmodule

bind xlat_inv_engine xlat_inv_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .inv_valid (inv_valid),
    .inv_ready (inv_ready),
    .inv_done  (inv_done),
    .lk_valid  (lk_valid),
    .lk_stall  (lk_stall),
    .lk_hit    (lk_hit)
);

// File: tb/xlat_inv_engine_tb_top.sv
`timescale 1ns/1ps
module xlat_inv_engine_tb_top;
    localparam int N     = 8;
    localparam int IDX_W = $clog2(N);
    localparam logic [19:0] VA = 20'h12345;
    localparam logic [19:0] VB = 20'h0ABCD;
    localparam logic [19:0] VC = 20'h54321;

    logic clk = 1'b0;
    logic rst_n;
    logic wr_en, wr_global, wr_leaf, wr_regime, wr_secure;
    logic [IDX_W-1:0] wr_idx;
    logic [19:0] wr_vpn;
    logic [7:0] wr_asid, wr_vmid;
    logic lk_valid, lk_regime, lk_secure, lk_stall, lk_hit;
    logic [19:0] lk_vpn;
    logic [7:0] lk_asid, lk_vmid;
    logic [IDX_W-1:0] lk_index;
    logic inv_valid, inv_ready, inv_regime, inv_secure, inv_vmid_cmp, inv_done;
    logic [31:0] inv_operand;
    logic [7:0] inv_vmid;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    xlat_inv_engine #(.NUM_ENTRIES(N)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_asid(wr_asid),
        .wr_global(wr_global), .wr_leaf(wr_leaf), .wr_regime(wr_regime),
        .wr_vmid(wr_vmid), .wr_secure(wr_secure),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
        .lk_regime(lk_regime), .lk_vmid(lk_vmid), .lk_secure(lk_secure),
        .lk_stall(lk_stall), .lk_hit(lk_hit), .lk_index(lk_index),
        .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_operand(inv_operand),
        .inv_regime(inv_regime), .inv_vmid(inv_vmid), .inv_secure(inv_secure),
        .inv_vmid_cmp(inv_vmid_cmp), .inv_done(inv_done)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wr_en = 0; wr_idx = '0; wr_vpn = '0; wr_asid = '0; wr_global = 0;
        wr_leaf = 0; wr_regime = 0; wr_vmid = '0; wr_secure = 0;
        lk_valid = 0; lk_vpn = '0; lk_asid = '0; lk_regime = 0; lk_vmid = '0;
        lk_secure = 0;
        inv_valid = 0; inv_operand = '0; inv_regime = 0; inv_vmid = '0;
        inv_secure = 0; inv_vmid_cmp = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input int idx, input logic [19:0] vpn, input logic [7:0] asid,
                      input logic glb, input logic leaf, input logic rgm,
                      input logic [7:0] vmid, input logic sec);
        wr_en = 1; wr_idx = IDX_W'(idx); wr_vpn = vpn; wr_asid = asid;
        wr_global = glb; wr_leaf = leaf; wr_regime = rgm; wr_vmid = vmid;
        wr_secure = sec;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic lookup(input logic [19:0] vpn, input logic [7:0] asid,
                          input logic rgm, input logic [7:0] vmid, input logic sec,
                          input bit eh, input int ei, input string req);
        lk_valid = 1; lk_vpn = vpn; lk_asid = asid; lk_regime = rgm;
        lk_vmid = vmid; lk_secure = sec;
        @(negedge clk);
        lk_valid = 0;
        chk(lk_hit == eh, {req, " hit"}, 32'(lk_hit), 32'(eh));
        if (eh) chk(lk_index == IDX_W'(ei), {req, " index"}, 32'(lk_index), 32'(ei));
    endtask

    task automatic inv_run(input logic [31:0] opnd, input logic rgm,
                           input logic [7:0] vmid, input logic sec, input logic cmp);
        chk(inv_ready == 1'b1, "R9 idle ready", 32'(inv_ready), 1);
        inv_valid = 1; inv_operand = opnd; inv_regime = rgm; inv_vmid = vmid;
        inv_secure = sec; inv_vmid_cmp = cmp;
        @(negedge clk);
        inv_valid = 0;
        for (int k = 0; k < N; k++) begin
            chk(inv_ready == 1'b0, "R9 busy ready low", 32'(inv_ready), 0);
            @(negedge clk);
        end
        chk(inv_ready && inv_done, "R9 done with ready", 32'({inv_ready, inv_done}), 3);
        @(negedge clk);
        chk(inv_done == 1'b0, "R9 done one cycle", 32'(inv_done), 0);
    endtask

    task automatic t_reset();
        do_reset();
        chk(inv_ready == 1'b1, "R1 ready", 32'(inv_ready), 1);
        chk(inv_done == 1'b0, "R1 done", 32'(inv_done), 0);
        chk(lk_hit == 1'b0, "R1 hit", 32'(lk_hit), 0);
        lookup(20'h0, 8'h0, 0, 8'h0, 0, 0, 0, "R1 empty lookup");
    endtask

    task automatic t_lookup();
        do_reset();
        wr(0, VA, 8'd5, 0, 1, 0, 8'd1, 0);
        wr(1, VB, 8'd9, 1, 1, 0, 8'd1, 0);
        wr(5, VA, 8'd5, 0, 1, 0, 8'd1, 0);
        lookup(VA, 8'd5, 0, 8'd1, 0, 1, 0, "R2 lowest index");
        lookup(VA, 8'd6, 0, 8'd1, 0, 0, 0, "R2 asid mismatch");
        lookup(VB, 8'd77, 0, 8'd1, 0, 1, 1, "R2 global any asid");
        lookup(VA, 8'd5, 0, 8'd2, 0, 0, 0, "R2 vmid mismatch");
    endtask

    task automatic t_inv_asid();
        do_reset();
        wr(0, VA, 8'd5, 0, 1, 0, 8'd1, 0);
        wr(1, VA, 8'd6, 0, 1, 0, 8'd1, 0);
        wr(2, VB, 8'd5, 0, 1, 0, 8'd1, 0);
        inv_run({VA, 4'hF, 8'd5}, 0, 8'd1, 0, 1);
        lookup(VA, 8'd5, 0, 8'd1, 0, 0, 0, "R3 R4 target removed");
        lookup(VA, 8'd6, 0, 8'd1, 0, 1, 1, "R4 other asid kept");
        lookup(VB, 8'd5, 0, 8'd1, 0, 1, 2, "R4 other page kept");
    endtask

    task automatic t_inv_global();
        do_reset();
        wr(0, VA, 8'd3, 1, 1, 0, 8'd1, 0);
        wr(1, VB, 8'd3, 1, 1, 0, 8'd1, 0);
        inv_run({VA, 4'h0, 8'd200}, 0, 8'd1, 0, 1);
        lookup(VA, 8'd3, 0, 8'd1, 0, 0, 0, "R5 global removed");
        lookup(VB, 8'd3, 0, 8'd1, 0, 1, 1, "R5 other global kept");
    endtask

    task automatic t_leaf();
        do_reset();
        wr(0, VA, 8'd5, 0, 0, 0, 8'd1, 0);
        wr(1, VA, 8'd5, 0, 1, 0, 8'd1, 0);
        inv_run({VA, 4'h0, 8'd5}, 0, 8'd1, 0, 1);
        lookup(VA, 8'd5, 0, 8'd1, 0, 1, 0, "R6 walk entry kept");
        wr(0, VC, 8'd5, 0, 0, 0, 8'd1, 0);
        lookup(VA, 8'd5, 0, 8'd1, 0, 0, 0, "R6 leaf entry removed");
    endtask

    task automatic t_filter();
        do_reset();
        wr(0, VA, 8'd5, 0, 1, 0, 8'd1, 0);
        wr(1, VA, 8'd5, 0, 1, 0, 8'd2, 0);
        wr(2, VA, 8'd5, 0, 1, 0, 8'd1, 1);
        wr(3, VA, 8'd5, 0, 1, 1, 8'd1, 0);
        inv_run({VA, 4'h0, 8'd5}, 0, 8'd1, 0, 1);
        lookup(VA, 8'd5, 0, 8'd1, 0, 0, 0, "R7 matching removed");
        lookup(VA, 8'd5, 0, 8'd2, 0, 1, 1, "R7 other vmid kept");
        lookup(VA, 8'd5, 0, 8'd1, 1, 1, 2, "R7 other security kept");
        lookup(VA, 8'd5, 1, 8'd0, 0, 1, 3, "R7 monitor entry kept");
        inv_run({VA, 4'h0, 8'd5}, 0, 8'd7, 0, 0);
        lookup(VA, 8'd5, 0, 8'd2, 0, 0, 0, "R7 vmid compare off");
        lookup(VA, 8'd5, 0, 8'd1, 1, 1, 2, "R7 security still filtered");
    endtask

    task automatic t_monitor();
        do_reset();
        wr(0, VA, 8'd5, 0, 1, 1, 8'd4, 1);
        wr(1, VA, 8'd5, 0, 1, 0, 8'd9, 1);
        inv_run({VA, 4'h0, 8'd5}, 1, 8'd0, 1, 1);
        lookup(VA, 8'd5, 1, 8'd0, 1, 0, 0, "R8 monitor removed");
        lookup(VA, 8'd5, 0, 8'd9, 1, 1, 1, "R8 guest kept");
    endtask

    task automatic t_stall();
        do_reset();
        wr(0, VA, 8'd5, 0, 1, 0, 8'd1, 0);
        inv_valid = 1; inv_operand = {VB, 4'h0, 8'd5}; inv_regime = 0;
        inv_vmid = 8'd1; inv_secure = 0; inv_vmid_cmp = 1;
        @(negedge clk);
        inv_valid = 0;
        chk(lk_stall == 1'b1, "R10 stall high", 32'(lk_stall), 1);
        lk_valid = 1; lk_vpn = VA; lk_asid = 8'd5; lk_regime = 0; lk_vmid = 8'd1;
        lk_secure = 0;
        wr_en = 1; wr_idx = IDX_W'(4); wr_vpn = VC; wr_asid = 8'd5; wr_global = 0;
        wr_leaf = 1; wr_regime = 0; wr_vmid = 8'd1; wr_secure = 0;
        @(negedge clk);
        lk_valid = 0; wr_en = 0;
        chk(lk_hit == 1'b0, "R10 no hit while busy", 32'(lk_hit), 0);
        for (int k = 0; k < 4 * N; k++) begin
            if (inv_done) break;
            @(negedge clk);
        end
        chk(inv_done == 1'b1, "R9 walk ends", 32'(inv_done), 1);
        chk(lk_stall == 1'b0, "R10 stall released", 32'(lk_stall), 0);
        lookup(VA, 8'd5, 0, 8'd1, 0, 1, 0, "R10 entry intact");
        lookup(VC, 8'd5, 0, 8'd1, 0, 0, 0, "R11 write dropped");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_lookup();
        t_inv_asid();
        t_inv_global();
        t_leaf();
        t_filter();
        t_monitor();
        t_stall();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule